// File: doc/BRIEF.md
# Call and Return Frame Sequencer

This block performs the memory side of subroutine linkage for a 32-bit processor core. The core raises a start strobe with an operation code and the current stack pointer, frame pointer, instruction address, branch target and trap handler address. The sequencer then runs a short series of word accesses on a data-memory port that has a ready handshake. When the series ends, it pulses done and presents the new stack pointer, frame pointer and program counter.

A call, whether it has an absolute target, a register target or is a software-interrupt entry, builds a three-word frame below the incoming stack pointer. The highest word is a static-chain slot that is reserved but never written. Below it sits the return address, and below that the caller's frame pointer. The lowest slot address becomes both the new stack pointer and the new frame pointer. A return reads the saved frame pointer and the return address back through the current frame pointer. It rebuilds the stack pointer from the frame pointer, not from the stack pointer, so a callee that left junk on its stack still returns cleanly.

The memory port moves whole words. Bits 31:24 of a word belong to the lowest byte address, which matches big-endian storage. The sequencer never splits or swaps a word.

Top module: `call_frame_seq`

## Requirements
- R1: With opSel = 2'b00 (absolute-target call) and incoming stack pointer S, the block writes the return address, instrAddr + 6, at S - 8 and the incoming frame pointer at S - 12. It makes exactly two memory accesses and never touches S - 4.
- R2: Both frame writes of any call form go out in a fixed order: the return-address slot first, then the saved frame pointer one word lower. The second write is not issued until the first has been accepted with memReady.
- R3: When a call of any form completes, spOut and fpOut both equal S - 12. pcOut equals targetIn for opSel 2'b00 and 2'b01.
- R4: With opSel = 2'b01 (register-target call), the return address written at S - 8 is instrAddr + 2.
- R5: With opSel = 2'b10 (return) and incoming frame pointer F, the block reads the word at F and then the word at F + 4, and writes nothing. On completion fpOut is the first word read, pcOut is the second word read, and spOut is F + 12, with 32-bit wraparound.
- R6: With opSel = 2'b11 (software-interrupt entry), the block builds the same frame as R1, with return address instrAddr + 6. On completion pcOut equals handlerIn, and spOut and fpOut equal S - 12.
- R7: After reset, spOut, fpOut and pcOut are zero and done and memReq are low. The outputs change only on the cycle done is high, and done is high for exactly one cycle per operation.
- R8: A start strobe that arrives while an operation is in progress has no effect. The running operation finishes with the values captured at its own start, and no extra memory accesses follow.
- R9: While memReq is high and memReady is low, the request, direction, address and write data hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| startReq | input | 1 | Start strobe; sampled only when idle |
| opSel | input | 2 | 00 absolute call, 01 register call, 10 return, 11 software-interrupt entry |
| spIn | input | 32 | Current stack pointer |
| fpIn | input | 32 | Current frame pointer |
| instrAddr | input | 32 | Address of the call or trap instruction |
| targetIn | input | 32 | Call target address |
| handlerIn | input | 32 | Software-interrupt handler address |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | 32 | Word byte address |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, valid with memReady |
| memReady | input | 1 | Access accepted this cycle |
| spOut | output | 32 | New stack pointer |
| fpOut | output | 32 | New frame pointer |
| pcOut | output | 32 | New program counter |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench goes after slot arithmetic at the 32-bit boundaries: a stack pointer of 8 makes the saved frame pointer land at 0xFFFFFFFC, and a frame pointer near the top makes the return rebuild a stack pointer of 4. An adder cut to fewer bits, or a slot offset off by a word, shows up there as a wrong address or a wrong spOut. It checks the two return-address offsets apart from each other and the handler selection for the interrupt entry, so a decoder that mixes up the operation forms returns to the wrong place. It randomly withholds memReady and pokes start during a busy sequence. A design that moves its request early, updates its outputs before done, or restarts on the stray strobe shows extra accesses, changed addresses or early output changes.

// File: rtl/call_frame_pkg.sv
package call_frame_pkg;

  typedef enum logic [1:0] {
    OP_CALL_ABS = 2'b00,
    OP_CALL_REG = 2'b01,
    OP_RETURN   = 2'b10,
    OP_TRAP     = 2'b11
  } frameOp_e;

  typedef enum logic [1:0] {
    SLOT_RETADDR = 2'd0,
    SLOT_OLDFP   = 2'd1,
    SLOT_LOADFP  = 2'd2,
    SLOT_LOADRA  = 2'd3
  } slotSel_e;

  typedef struct packed {
    logic     latchIn;
    logic     capFp;
    logic     commit;
    logic     commitRet;
    logic     memReq;
    logic     memWe;
    slotSel_e slot;
  } seqCtrl_t;

endpackage

// File: rtl/call_frame_ctrl.sv
module call_frame_ctrl
  import call_frame_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     startReq,
  input  logic [1:0] opSel,
  input  logic     memReady,
  output seqCtrl_t ctrl,
  output logic     done
);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_RA,
    ST_WR_FP,
    ST_RD_FP,
    ST_RD_RA
  } seqState_e;

  seqState_e state, stateNext;

  always_comb begin
    stateNext = state;
    ctrl      = '0;
    ctrl.slot = SLOT_RETADDR;
    unique case (state)
      ST_IDLE: begin
        if (startReq) begin
          ctrl.latchIn = 1'b1;
          stateNext    = (frameOp_e'(opSel) == OP_RETURN) ? ST_RD_FP : ST_WR_RA;
        end
      end
      ST_WR_RA: begin
        ctrl.memReq = 1'b1;
        ctrl.memWe  = 1'b1;
        ctrl.slot   = SLOT_RETADDR;
        if (memReady) stateNext = ST_WR_FP;
      end
      ST_WR_FP: begin
        ctrl.memReq = 1'b1;
        ctrl.memWe  = 1'b1;
        ctrl.slot   = SLOT_OLDFP;
        if (memReady) begin
          ctrl.commit = 1'b1;
          stateNext   = ST_IDLE;
        end
      end
      ST_RD_FP: begin
        ctrl.memReq = 1'b1;
        ctrl.slot   = SLOT_LOADFP;
        if (memReady) begin
          ctrl.capFp = 1'b1;
          stateNext  = ST_RD_RA;
        end
      end
      ST_RD_RA: begin
        ctrl.memReq = 1'b1;
        ctrl.slot   = SLOT_LOADRA;
        if (memReady) begin
          ctrl.commit    = 1'b1;
          ctrl.commitRet = 1'b1;
          stateNext      = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= ctrl.commit;
    end
  end

endmodule

// File: rtl/call_frame_dp.sv
module call_frame_dp
  import call_frame_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int LONG_STEP  = 6,
  parameter int SHORT_STEP = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtrl_t          ctrl,
  input  logic [1:0]        opSel,
  input  logic [DATA_W-1:0] spIn,
  input  logic [DATA_W-1:0] fpIn,
  input  logic [DATA_W-1:0] instrAddr,
  input  logic [DATA_W-1:0] targetIn,
  input  logic [DATA_W-1:0] handlerIn,
  input  logic [DATA_W-1:0] memRdata,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] spOut,
  output logic [DATA_W-1:0] fpOut,
  output logic [DATA_W-1:0] pcOut
);

  localparam int WORD_BYTES = DATA_W / 8;
  localparam logic [DATA_W-1:0] RA_OFF   = DATA_W'(2 * WORD_BYTES);
  localparam logic [DATA_W-1:0] LINK_OFF = DATA_W'(3 * WORD_BYTES);
  localparam logic [DATA_W-1:0] WORD_OFF = DATA_W'(WORD_BYTES);

  logic [DATA_W-1:0] spLat, fpLat, pcTgt, retAddr, loadedFp;
  logic [DATA_W-1:0] frameBase;
  logic [DATA_W-1:0] retStep;

  assign retStep   = (frameOp_e'(opSel) == OP_CALL_REG) ? DATA_W'(SHORT_STEP)
                                                        : DATA_W'(LONG_STEP);
  assign frameBase = spLat - LINK_OFF;

  always_comb begin
    unique case (ctrl.slot)
      SLOT_RETADDR: memAddr = spLat - RA_OFF;
      SLOT_OLDFP:   memAddr = frameBase;
      SLOT_LOADFP:  memAddr = fpLat;
      SLOT_LOADRA:  memAddr = fpLat + WORD_OFF;
      default:      memAddr = fpLat;
    endcase
    memWdata = (ctrl.slot == SLOT_RETADDR) ? retAddr : fpLat;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      spLat    <= '0;
      fpLat    <= '0;
      pcTgt    <= '0;
      retAddr  <= '0;
      loadedFp <= '0;
    end else begin
      if (ctrl.latchIn) begin
        spLat   <= spIn;
        fpLat   <= fpIn;
        pcTgt   <= (frameOp_e'(opSel) == OP_TRAP) ? handlerIn : targetIn;
        retAddr <= instrAddr + retStep;
      end
      if (ctrl.capFp) loadedFp <= memRdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      spOut <= '0;
      fpOut <= '0;
      pcOut <= '0;
    end else if (ctrl.commit) begin
      if (ctrl.commitRet) begin
        spOut <= fpLat + LINK_OFF;
        fpOut <= loadedFp;
        pcOut <= memRdata;
      end else begin
        spOut <= frameBase;
        fpOut <= frameBase;
        pcOut <= pcTgt;
      end
    end
  end

endmodule

// File: rtl/call_frame_seq.sv
module call_frame_seq
  import call_frame_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int LONG_STEP  = 6,
  parameter int SHORT_STEP = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [1:0]        opSel,
  input  logic [DATA_W-1:0] spIn,
  input  logic [DATA_W-1:0] fpIn,
  input  logic [DATA_W-1:0] instrAddr,
  input  logic [DATA_W-1:0] targetIn,
  input  logic [DATA_W-1:0] handlerIn,
  output logic              memReq,
  output logic              memWe,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memReady,
  output logic [DATA_W-1:0] spOut,
  output logic [DATA_W-1:0] fpOut,
  output logic [DATA_W-1:0] pcOut,
  output logic              done
);

  seqCtrl_t ctrl;

  call_frame_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .opSel    (opSel),
    .memReady (memReady),
    .ctrl     (ctrl),
    .done     (done)
  );

  call_frame_dp #(
    .DATA_W     (DATA_W),
    .LONG_STEP  (LONG_STEP),
    .SHORT_STEP (SHORT_STEP)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .opSel     (opSel),
    .spIn      (spIn),
    .fpIn      (fpIn),
    .instrAddr (instrAddr),
    .targetIn  (targetIn),
    .handlerIn (handlerIn),
    .memRdata  (memRdata),
    .memAddr   (memAddr),
    .memWdata  (memWdata),
    .spOut     (spOut),
    .fpOut     (fpOut),
    .pcOut     (pcOut)
  );

  assign memReq = ctrl.memReq;
  assign memWe  = ctrl.memWe;

endmodule

// File: rtl/call_frame_seq_chk.sv
module call_frame_seq_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              memReq,
  input logic              memWe,
  input logic [DATA_W-1:0] memAddr,
  input logic [DATA_W-1:0] memWdata,
  input logic              memReady,
  input logic [DATA_W-1:0] spOut,
  input logic [DATA_W-1:0] fpOut,
  input logic [DATA_W-1:0] pcOut,
  input logic              done
);

  localparam logic [DATA_W-1:0] WORD_OFF = DATA_W'(DATA_W / 8);
  localparam logic [DATA_W-1:0] LINK_OFF = DATA_W'(3 * (DATA_W / 8));

  logic              wrSeen, rdSeen;
  logic [DATA_W-1:0] lastWrAddr, firstRdAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrSeen      <= 1'b0;
      rdSeen      <= 1'b0;
      lastWrAddr  <= '0;
      firstRdAddr <= '0;
    end else begin
      if (done) begin
        wrSeen <= 1'b0;
        rdSeen <= 1'b0;
      end
      if (memReq && memReady && memWe) begin
        wrSeen     <= 1'b1;
        lastWrAddr <= memAddr;
      end
      if (memReq && memReady && !memWe && !rdSeen) begin
        rdSeen      <= 1'b1;
        firstRdAddr <= memAddr;
      end
    end
  end

  AST_WR_STEP_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWe && wrSeen |-> memAddr == lastWrAddr - WORD_OFF); // R2

  AST_CALL_LINK: assert property (@(posedge clk) disable iff (!rstN)
    done && wrSeen |-> spOut == fpOut && spOut == lastWrAddr); // R3

  AST_RET_SP_REBUILD: assert property (@(posedge clk) disable iff (!rstN)
    done && rdSeen |-> spOut == firstRdAddr + LINK_OFF); // R5

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R7

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(spOut) && $stable(fpOut) && $stable(pcOut)); // R7

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memReady |=> memReq && $stable(memAddr) && $stable(memWe)
                            && $stable(memWdata)); // R9

endmodule

bind call_frame_seq call_frame_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .memReq   (memReq),
  .memWe    (memWe),
  .memAddr  (memAddr),
  .memWdata (memWdata),
  .memReady (memReady),
  .spOut    (spOut),
  .fpOut    (fpOut),
  .pcOut    (pcOut),
  .done     (done)
);

// File: tb/call_frame_seq_bench.sv
`timescale 1ns/1ps
module call_frame_seq_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic [1:0]  opSel = 2'b00;
  logic [31:0] spIn = '0, fpIn = '0, instrAddr = '0, targetIn = '0, handlerIn = '0;
  logic        memReq, memWe;
  logic [31:0] memAddr, memWdata;
  logic [31:0] memRdata = '0;
  logic        memReady = 1'b0;
  logic [31:0] spOut, fpOut, pcOut;
  logic        done;

  int nChecks = 0;
  int nFail   = 0;
  bit stallOn = 1'b0;
  int holdErr = 0;

  logic [31:0] logAddr [8];
  logic [31:0] logData [8];
  bit          logWe   [8];
  int          logN = 0;

  always #10 clk = ~clk;

  call_frame_seq u_call_frame_seq (
    .clk(clk), .rstN(rstN), .startReq(startReq), .opSel(opSel),
    .spIn(spIn), .fpIn(fpIn), .instrAddr(instrAddr), .targetIn(targetIn),
    .handlerIn(handlerIn), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata), .memReady(memReady),
    .spOut(spOut), .fpOut(fpOut), .pcOut(pcOut), .done(done)
  );

  function automatic logic [31:0] rdWord(input logic [31:0] a);
    return a * 32'h9E3779B1 + 32'h0137_5AC3;
  endfunction

  // memory responder, acts on falling edges
  bit          prevStall = 1'b0;
  logic [31:0] prevAddr  = '0;
  always @(negedge clk) begin
    if (rstN && memReq) begin
      if (prevStall && memAddr != prevAddr) holdErr++;
      if (!stallOn || ($urandom_range(0, 3) != 0)) begin
        memReady = 1'b1;
        memRdata = memWe ? 32'hDEAD_0000 : rdWord(memAddr);
        if (logN < 8) begin
          logAddr[logN] = memAddr;
          logData[logN] = memWe ? memWdata : memRdata;
          logWe[logN]   = memWe;
        end
        logN++;
        prevStall = 1'b0;
      end else begin
        memReady  = 1'b0;
        prevStall = 1'b1;
        prevAddr  = memAddr;
      end
    end else begin
      memReady  = 1'b0;
      prevStall = 1'b0;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic runOp(input logic [1:0] op, input logic [31:0] sp, input logic [31:0] fp,
                       input logic [31:0] ia, input logic [31:0] tg, input logic [31:0] hd,
                       input bit poke);
    logic [31:0] preSp, preFp, prePc, eRet, eSp, eFp, ePc;
    bit seen, moved;
    string fTag;
    preSp = spOut; preFp = fpOut; prePc = pcOut;
    fTag = (op == 2'b00) ? "R1" : (op == 2'b01) ? "R4" : (op == 2'b11) ? "R6" : "R5";
    eRet = ia + ((op == 2'b01) ? 32'd2 : 32'd6);
    if (op == 2'b10) begin
      eSp = fp + 32'd12; eFp = rdWord(fp); ePc = rdWord(fp + 32'd4);
    end else begin
      eSp = sp - 32'd12; eFp = sp - 32'd12; ePc = (op == 2'b11) ? hd : tg;
    end
    @(negedge clk);
    logN = 0;
    opSel = op; spIn = sp; fpIn = fp; instrAddr = ia; targetIn = tg; handlerIn = hd;
    startReq = 1'b1;
    @(negedge clk);
    if (poke) begin
      opSel = ~op; spIn = ~sp; fpIn = ~fp; instrAddr = ~ia; targetIn = ~tg; handlerIn = ~hd;
    end else startReq = 1'b0;
    seen = 1'b0; moved = 1'b0;
    for (int cyc = 0; cyc < 200 && !seen; cyc++) begin
      if (done) seen = 1'b1;
      else begin
        if (spOut !== preSp || fpOut !== preFp || pcOut !== prePc) moved = 1'b1;
        if (cyc == 1) startReq = 1'b0;
        @(negedge clk);
      end
    end
    startReq = 1'b0;
    chk("R7 done reached", 32'(seen), 32'd1);
    chk("R7 outputs held before done", 32'(moved), 32'd0);
    chk({fTag, " access count"}, 32'(logN), 32'd2);
    if (op == 2'b10) begin
      chk("R5 first read at FP", logAddr[0], fp);
      chk("R5 second read at FP+4", logAddr[1], fp + 32'd4);
      chk("R5 reads only", {31'd0, logWe[0] | logWe[1]}, 32'd0);
    end else begin
      chk({fTag, " R2 first write at SP-8"}, logAddr[0], sp - 32'd8);
      chk({fTag, " return address value"}, logData[0], eRet);
      chk({fTag, " R2 second write at SP-12"}, logAddr[1], sp - 32'd12);
      chk({fTag, " saved FP value"}, logData[1], fp);
      chk({fTag, " writes"}, {31'd0, logWe[0] & logWe[1]}, 32'd1);
    end
    chk({fTag, " R3 spOut"}, spOut, eSp);
    chk({fTag, " R3 fpOut"}, fpOut, eFp);
    chk({fTag, " R3 pcOut"}, pcOut, ePc);
    @(negedge clk);
    chk("R7 done single cycle", {31'd0, done}, 32'd0);
    @(negedge clk);
    chk(poke ? "R8 no access after stray start" : "R8 idle after done", 32'(logN), 32'd2);
    chk(poke ? "R8 spOut kept" : "R7 spOut kept", spOut, eSp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk("R7 reset spOut", spOut, 32'd0);
    chk("R7 reset fpOut", fpOut, 32'd0);
    chk("R7 reset pcOut", pcOut, 32'd0);
    chk("R7 reset done/memReq", {30'd0, done, memReq}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // directed cases
    runOp(2'b00, 32'h0000_1000, 32'h0000_2000, 32'h0000_0400, 32'h0000_8000, 32'h0, 1'b0); // R1
    runOp(2'b01, 32'h0000_1000, 32'h0000_1100, 32'h0000_0400, 32'h0000_9000, 32'h0, 1'b0); // R4
    runOp(2'b11, 32'h0000_3000, 32'h0000_3100, 32'h0000_0500, 32'h1111_1111, 32'h0000_C000, 1'b0); // R6
    runOp(2'b10, 32'h0, 32'h0000_0FF4, 32'h0, 32'h0, 32'h0, 1'b0); // R5
    runOp(2'b00, 32'h0000_0008, 32'hABCD_0000, 32'hFFFF_FFFC, 32'h40, 32'h0, 1'b0); // wrap R1
    runOp(2'b10, 32'h0, 32'hFFFF_FFF8, 32'h0, 32'h0, 32'h0, 1'b0); // wrap R5
    stallOn = 1'b1;
    runOp(2'b00, 32'h0000_2000, 32'h0000_2100, 32'h0000_0600, 32'h0000_A000, 32'h0, 1'b1); // R8
    runOp(2'b10, 32'h0, 32'h0000_1FF4, 32'h0, 32'h0, 32'h0, 1'b1); // R8

    for (int i = 0; i < 40; i++) begin
      logic [1:0] op;
      op = 2'($urandom_range(0, 3));
      stallOn = ($urandom_range(0, 1) == 1);
      runOp(op, $urandom & 32'hFFFF_FFFC, $urandom & 32'hFFFF_FFFC, $urandom & 32'hFFFF_FFFE,
            $urandom & 32'hFFFF_FFFE, $urandom & 32'hFFFF_FFFE, ($urandom_range(0, 3) == 0));
    end

    chk("R9 request held while stalled", 32'(holdErr), 32'd0);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule